// File: doc/BRIEF.md
# Switchable-Depth Arithmetic Pipeline

This block is a chain of combinational transform stages with a register after each stage. Every second register carries a 2:1 selector that can route the register's input straight through to the next stage. With those registers bypassed, two neighbouring stages behave as one stage. The number of cycles from input to output then halves, while the function computed stays the same. The intended use is to run the half-depth arrangement at half the clock rate, so that the time to complete one operation is the same in both arrangements.

A valid flag travels with every data word through the same registers and selectors. Output valid therefore lines up with output data in either arrangement. The depth request input is sampled continuously. The active arrangement changes only on an edge at which no word is in flight and no new word is being accepted. Until then the request waits, and the active arrangement stays as it was. A busy output reports that at least one word is in flight.

Top module: `flex_depth_pipe`

## Requirements
- R1: While reset is high, the next edge clears every in-flight word, so `out_valid` and `busy` read 0, and the active arrangement becomes full depth. A word applied right after reset therefore takes the full-depth latency, even if `half_req` is already 1.
- R2: In full depth (`half_req` = 0 accepted), a word sampled with `in_valid` = 1 on edge e appears with `out_valid` = 1 after edge e+NUM_STAGES-1, which is NUM_STAGES cycles of latency (4 by default).
- R3: In half depth (`half_req` = 1 accepted), the same word appears after edge e+NUM_STAGES/2-1, which is 2 cycles of latency by default.
- R4: `out_data` equals the same function of `in_data` in both arrangements. With the defaults the stages apply, in order: add 0x9E3779B9, rotate left by 5, XOR with 0xA5A55A5A, add 0x9E3779BC, all modulo 2^32. In general, stage k adds ADD_BASE+k when k mod 3 = 0, rotates left by (2k+3) mod DATA_W when k mod 3 = 1, and XORs with XOR_BASE when k mod 3 = 2.
- R5: The active arrangement takes the value of `half_req` only on an edge where `busy` is 0 and `in_valid` is 0. A request made while words are in flight, or while input keeps arriving, does not change the latency of any word.
- R6: `busy` is 1 exactly when at least one accepted word has not yet left the output register.
- R7: Words sampled on consecutive edges come out on consecutive cycles in the same order, one per cycle, in both arrangements.
- R8: A cycle with `in_valid` = 0 produces no word: `out_valid` is 0 in the cycle where such a word would have appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W | Input word |
| half_req | input | 1 | Requested arrangement: 1 = half depth, 0 = full depth |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Transformed word |
| busy | output | 1 | At least one word in flight |

## Verification
Random words arrive with random gaps in each arrangement. This shows whether latency depends on the active arrangement rather than on the request, and whether bubbles stay bubbles. Unbroken bursts show whether order and one-word-per-cycle throughput hold, with no merged or dropped words. Mode requests raised mid-stream and while input keeps arriving show whether a switch waits for an empty, idle pipeline. The all-zero, all-one and alternating-bit words, each run in both arrangements, show whether the carry, rotation and XOR steps match the same function at full depth and at half depth.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_ROT = 2'd1,
      OP_XOR = 2'd2
   } stage_op_e;

   function automatic stage_op_e op_of(input int idx);
      case (idx % 3)
         0:       return OP_ADD;
         1:       return OP_ROT;
         default: return OP_XOR;
      endcase
   endfunction

   function automatic int rot_of(input int idx, input int width);
      return (2 * idx + 3) % width;
   endfunction

endpackage

// File: rtl/fdp_stage.sv
module fdp_stage
   import fdp_pkg::*;
#(
   parameter int            W        = 32,
   parameter int            IDX      = 0,
   parameter logic [W-1:0]  ADD_BASE = '0,
   parameter logic [W-1:0]  XOR_BASE = '0
) (
   input  logic [W-1:0] x_i,
   output logic [W-1:0] y_o
);
   localparam stage_op_e OP  = op_of(IDX);
   localparam int        ROT = rot_of(IDX, W);
   localparam logic [W-1:0] ADD_K = ADD_BASE + W'(IDX);

   generate
      if (OP == OP_ADD) begin : g_add
         assign y_o = x_i + ADD_K;
      end else if (OP == OP_ROT) begin : g_rot
         if (ROT == 0) begin : g_none
            assign y_o = x_i;
         end else begin : g_shift
            assign y_o = (x_i << ROT) | (x_i >> (W - ROT));
         end
      end else begin : g_xor
         assign y_o = x_i ^ XOR_BASE;
      end
   endgenerate
endmodule

// File: rtl/fdp_fixed_reg.sv
module fdp_fixed_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         vld_i,
   input  logic [W-1:0] dat_i,
   output logic         vld_o,
   output logic [W-1:0] dat_o
);
   logic         vld_q;
   logic [W-1:0] dat_q;

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= vld_i;
   end

   always_ff @(posedge clk) begin
      if (vld_i) dat_q <= dat_i;
   end

   assign vld_o = vld_q;
   assign dat_o = dat_q;

   // R6: a word held here must have been offered on the previous edge
   p_hold_origin_r6: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> $past(vld_i));
endmodule

// File: rtl/fdp_bypass_reg.sv
module fdp_bypass_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bypass_i,
   input  logic         vld_i,
   input  logic [W-1:0] dat_i,
   output logic         vld_o,
   output logic [W-1:0] dat_o,
   output logic         held_o
);
   logic         cap_vld;
   logic         q_vld;
   logic [W-1:0] q_dat;

   assign cap_vld = vld_i & ~bypass_i;

   fdp_fixed_reg #(.W(W)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .vld_i (cap_vld),
      .dat_i (dat_i),
      .vld_o (q_vld),
      .dat_o (q_dat)
   );

   assign vld_o  = bypass_i ? vld_i : q_vld;
   assign dat_o  = bypass_i ? dat_i : q_dat;
   assign held_o = q_vld;

   // R3: in the merged arrangement nothing is left parked in the skipped register
   p_skip_empty_r3: assert property (@(posedge clk) disable iff (rst)
      (bypass_i && $past(bypass_i)) |-> !q_vld);
endmodule

// File: rtl/fdp_mode_ctl.sv
module fdp_mode_ctl
   import fdp_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_i,
   input  logic in_valid_i,
   input  logic busy_i,
   output logic half_o
);
   logic half_q;
   logic may_switch;

   assign may_switch = ~busy_i & ~in_valid_i;

   always_ff @(posedge clk) begin
      if (rst)             half_q <= 1'b0;
      else if (may_switch) half_q <= req_i;
   end

   assign half_o = half_q;

   // R5: the arrangement changes only when empty and idle
   p_switch_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (half_q != $past(half_q)) |-> $past(!busy_i && !in_valid_i));
endmodule

// File: rtl/flex_depth_pipe.sv
module flex_depth_pipe
   import fdp_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                NUM_STAGES = 4,
   parameter logic [DATA_W-1:0] ADD_BASE   = DATA_W'(32'h9E3779B9),
   parameter logic [DATA_W-1:0] XOR_BASE   = DATA_W'(32'hA5A55A5A)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              half_req,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              busy
);
   localparam int LAST = NUM_STAGES - 1;

   generate
      if (NUM_STAGES < 2 || (NUM_STAGES % 2) != 0) begin : g_bad_depth
         $error("NUM_STAGES must be even and at least 2");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic [NUM_STAGES-1:0][DATA_W-1:0] stg_in;
   logic [NUM_STAGES-1:0][DATA_W-1:0] stg_out;
   logic [NUM_STAGES-1:0][DATA_W-1:0] bnd_dat;
   logic [NUM_STAGES-1:0]             stg_vld;
   logic [NUM_STAGES-1:0]             bnd_vld;
   logic [NUM_STAGES-1:0]             held;
   logic                              half_mode;

   assign busy = |held;

   fdp_mode_ctl u_mode (
      .clk        (clk),
      .rst        (rst),
      .req_i      (half_req),
      .in_valid_i (in_valid),
      .busy_i     (busy),
      .half_o     (half_mode)
   );

   generate
      for (genvar k = 0; k < NUM_STAGES; k++) begin : g_lane
         if (k == 0) begin : g_head
            assign stg_in[k]  = in_data;
            assign stg_vld[k] = in_valid;
         end else begin : g_link
            assign stg_in[k]  = bnd_dat[k-1];
            assign stg_vld[k] = bnd_vld[k-1];
         end

         fdp_stage #(
            .W        (DATA_W),
            .IDX      (k),
            .ADD_BASE (ADD_BASE),
            .XOR_BASE (XOR_BASE)
         ) u_stage (
            .x_i (stg_in[k]),
            .y_o (stg_out[k])
         );

         if ((k % 2) == 0) begin : g_skip
            fdp_bypass_reg #(.W(DATA_W)) u_bnd (
               .clk      (clk),
               .rst      (rst),
               .bypass_i (half_mode),
               .vld_i    (stg_vld[k]),
               .dat_i    (stg_out[k]),
               .vld_o    (bnd_vld[k]),
               .dat_o    (bnd_dat[k]),
               .held_o   (held[k])
            );
         end else begin : g_fixed
            fdp_fixed_reg #(.W(DATA_W)) u_bnd (
               .clk   (clk),
               .rst   (rst),
               .vld_i (stg_vld[k]),
               .dat_i (stg_out[k]),
               .vld_o (bnd_vld[k]),
               .dat_o (bnd_dat[k])
            );
            assign held[k] = bnd_vld[k];
         end
      end
   endgenerate

   assign out_valid = bnd_vld[LAST];
   assign out_data  = bnd_dat[LAST];

   // R6: an accepted word is always visible as in flight on the next cycle
   p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> busy);

   // R3: in half depth each output word was accepted two edges earlier
   p_half_latency_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && half_mode && NUM_STAGES == 4) |-> $past(in_valid, 2));

   // R8: an output word never appears from an empty pipeline
   p_no_phantom_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(busy));
endmodule

// File: tb/flex_depth_pipe_test.sv
`timescale 1ns/1ps
module flex_depth_pipe_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         half_req = 1'b0;
   logic         out_valid;
   logic [W-1:0] out_data;
   logic         busy;

   always #2.5 clk = ~clk;

   flex_depth_pipe uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .half_req  (half_req),
      .out_valid (out_valid),
      .out_data  (out_data),
      .busy      (busy)
   );

   int     errors = 0;
   int     checks = 0;
   bit     done = 0;
   int     t = 0;
   int     pend = 0;
   bit     model_half = 0;
   bit     busy_model = 0;
   string  ph_tag = "";
   bit           sb_v   [64];
   logic [W-1:0] sb_dat [64];
   string        sb_tag [64];

   function automatic logic [W-1:0] ref_fn(input logic [W-1:0] x);
      logic [W-1:0] a;
      a = x + 32'h9E3779B9;
      a = {a[26:0], a[31:27]};
      a = a ^ 32'hA5A55A5A;
      a = a + 32'h9E3779BC;
      return a;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s step %0d: actual=%h expected=%h", tag, t, act, exp);
      end
   endtask

   task automatic do_checks();
      int s;
      s = t % 64;
      busy_model = (pend > 0);
      chk(busy === busy_model, "R6 busy", W'(busy), W'(busy_model));
      if (sb_v[s]) begin
         chk(out_valid === 1'b1, sb_tag[s], W'(out_valid), 1);
         if (out_valid === 1'b1)
            chk(out_data === sb_dat[s], "R4 data", out_data, sb_dat[s]);
         sb_v[s] = 0;
         pend--;
      end else begin
         chk(out_valid === 1'b0, "R8 bubble", W'(out_valid), 0);
      end
   endtask

   task automatic apply(input bit v, input logic [W-1:0] d, input bit req);
      int lat;
      int s;
      in_valid = v;
      in_data  = d;
      half_req = req;
      if (v) begin
         lat = model_half ? 2 : 4;
         s = (t + lat) % 64;
         sb_v[s]   = 1;
         sb_dat[s] = ref_fn(d);
         if (ph_tag != "")  sb_tag[s] = ph_tag;
         else if (model_half) sb_tag[s] = "R3 latency";
         else               sb_tag[s] = "R2 latency";
         pend++;
      end
      if (!busy_model && !v) model_half = req;
   endtask

   task automatic step(input bit v, input logic [W-1:0] d, input bit req);
      do_checks();
      apply(v, d, req);
      @(negedge clk);
      t++;
   endtask

   task automatic idle(input int n, input bit req);
      for (int i = 0; i < n; i++) step(1'b0, '0, req);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) sb_v[i] = 0;
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(out_valid === 1'b0, "R1 reset valid", W'(out_valid), 0);
      chk(busy === 1'b0, "R1 reset busy", W'(busy), 0);
      rst = 1'b0;

      // R1 + R5: half requested at once, but input keeps flowing: full depth holds
      ph_tag = "R1 default full latency";
      for (int i = 0; i < 6; i++) step(1'b1, $urandom, 1'b1);
      ph_tag = "";
      idle(8, 1'b1);

      // R3 random half-depth stream with gaps
      for (int i = 0; i < 300; i++) step(($urandom % 10) < 7, $urandom, 1'b1);
      // R7 unbroken burst in half depth
      ph_tag = "R7 half burst";
      for (int i = 0; i < 20; i++) step(1'b1, $urandom, 1'b1);
      ph_tag = "";
      // back to full depth, R2 random stream
      for (int i = 0; i < 300; i++) step(($urandom % 10) < 6, $urandom, 1'b0);
      idle(6, 1'b0);
      ph_tag = "R7 full burst";
      for (int i = 0; i < 20; i++) step(1'b1, $urandom, 1'b0);
      // R5: request half mid-burst, latency must stay full
      ph_tag = "R5 request while busy";
      for (int i = 0; i < 10; i++) step(1'b1, $urandom, 1'b1);
      ph_tag = "";
      idle(6, 1'b1);

      // R4 corner words in both arrangements
      ph_tag = "R4 corner half";
      step(1'b1, 32'h0, 1'b1); step(1'b1, 32'hFFFFFFFF, 1'b1);
      step(1'b1, 32'h55555555, 1'b1); step(1'b1, 32'h61C88647, 1'b1);
      ph_tag = "";
      idle(6, 1'b0);
      ph_tag = "R4 corner full";
      step(1'b1, 32'h0, 1'b0); step(1'b1, 32'hFFFFFFFF, 1'b0);
      step(1'b1, 32'h55555555, 1'b0); step(1'b1, 32'h61C88647, 1'b0);
      ph_tag = "";

      // mixed random with occasional requested flips
      begin
         bit r;
         r = 1'b0;
         for (int i = 0; i < 2000; i++) begin
            if (($urandom % 25) == 0) r = ~r;
            step(($urandom % 10) < 5, $urandom, r);
         end
      end
      idle(8, 1'b0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule